// File: doc/BRIEF.md
# Mixed-Latency Integer Lane

This block is one integer execution lane of a vector datapath. Each issue presents an opcode, three 32-bit source words and an incoming carry bit. The lane returns a 32-bit result word and a carry/borrow flag. Most operations finish in a single cycle: addition and subtraction with and without a carry input, and 24-bit multiplies in signed and unsigned forms. The 24-bit multiplies come in three kinds: product low word, product plus a 32-bit addend, and the 16-bit upper part of the 48-bit product.

Full 32-bit multiplies return either the low or the high word of the 64-bit product. They run on a separate multi-cycle unit. While one of them is in flight, the lane drops its ready signal so that the issuing logic holds back. Every accepted operation yields exactly one result, marked by a one-cycle valid pulse.

Top module: `int_alu_lane`

## Requirements
- R1: Opcode 0 (add) returns a+b mod 2^32 with out_carry set to bit 32 of the sum. Opcode 1 (subtract) returns a-b mod 2^32 with out_carry set when b > a as unsigned values.
- R2: Opcode 2 returns a+b+in_cin with carry-out. Opcode 3 returns a-b-in_cin with out_carry set when b+in_cin > a as unsigned values.
- R3: Opcodes 4 (unsigned) and 5 (signed) multiply bits 23:0 of a and b and return the low 32 bits of the 48-bit product. For the signed form, bit 23 is the sign. Bits 31:24 of the sources have no effect.
- R4: Opcodes 6 (unsigned) and 7 (signed) return the 24-bit product of a and b, as in R3, plus the full 32-bit c, mod 2^32.
- R5: Opcodes 8 (unsigned) and 9 (signed) return bits 47:32 of the 48-bit product. Opcode 8 zero-extends this value to 32 bits and opcode 9 sign-extends it.
- R6: Opcodes 10/11 return the low word and opcodes 12/13 return the high word of the 64-bit product of a and b. Even codes treat the operands as unsigned and odd codes as signed.
- R7: Opcodes 0 to 9, 14 and 15 raise out_valid in the cycle after issue and keep in_ready high, so they can be issued on every cycle.
- R8: Opcodes 10 to 13 hold in_ready low for three cycles after issue, then raise out_valid with in_ready high in the fourth cycle. in_valid during the stall is ignored and yields no result.
- R9: out_carry is 0 for every result of opcodes 4 to 15.
- R10: Opcodes 14 and 15 return a zero result.
- R11: A synchronous active-high rst clears out_valid and any in-flight multiply. After rst, in_ready is high and no stale result appears.
- R12: out_valid is a one-cycle pulse, and there is exactly one pulse for each accepted issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Lane can accept an issue |
| in_op | input | 4 | Opcode |
| in_a | input | 32 | Source 0 |
| in_b | input | 32 | Source 1 |
| in_c | input | 32 | Source 2 (addend for multiply-add) |
| in_cin | input | 1 | Incoming carry or borrow |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 32 | Result word |
| out_carry | output | 1 | Carry or borrow out |

## Verification
A wrong countdown in the wide multiplier shows up at in_ready within four cycles of the issue. It appears as a stall that is too short or too long, or as a result pulse in the wrong cycle. A corrupted operand or signedness latch shows as a wrong result word on the single valid pulse, with no other port affected. A lost reset of the in-flight state shows as a stray valid pulse or a low in_ready within three cycles after reset is released.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int WORD_W   = 32;
  localparam int NARROW_W = 24;
  localparam int PROD_N_W = 2 * NARROW_W;
  localparam int PROD_W_W = 2 * WORD_W;
  localparam int HIGH_N_W = PROD_N_W - WORD_W;
  localparam int OP_W     = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD       = 4'd0,
    OP_SUB       = 4'd1,
    OP_ADDC      = 4'd2,
    OP_SUBB      = 4'd3,
    OP_MUL24_U   = 4'd4,
    OP_MUL24_S   = 4'd5,
    OP_MAD24_U   = 4'd6,
    OP_MAD24_S   = 4'd7,
    OP_MULHI24_U = 4'd8,
    OP_MULHI24_S = 4'd9,
    OP_MULLO_U   = 4'd10,
    OP_MULLO_S   = 4'd11,
    OP_MULHI_U   = 4'd12,
    OP_MULHI_S   = 4'd13
  } ialu_op_e;

  // Wide multiplies go to the multi-cycle unit.
  function automatic logic op_is_slow(input logic [OP_W-1:0] op);
    return (op == OP_MULLO_U) || (op == OP_MULLO_S) ||
           (op == OP_MULHI_U) || (op == OP_MULHI_S);
  endfunction

  // The carry flag sits in the top bit. Subtraction is done as
  // a + ~b + ~borrow_in, so the carry out is inverted to give a borrow.
  function automatic logic [WORD_W:0] addsub_fn(input logic [OP_W-1:0] op,
                                                input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b,
                                                input logic cin);
    logic              is_sub;
    logic              ci;
    logic [WORD_W-1:0] bo;
    logic [WORD_W:0]   t;
    is_sub = (op == OP_SUB) || (op == OP_SUBB);
    bo     = is_sub ? ~b : b;
    case (op)
      OP_SUB:  ci = 1'b1;
      OP_ADDC: ci = cin;
      OP_SUBB: ci = ~cin;
      default: ci = 1'b0;
    endcase
    t = {1'b0, a} + {1'b0, bo} + {{WORD_W{1'b0}}, ci};
    return {t[WORD_W] ^ is_sub, t[WORD_W-1:0]};
  endfunction

  // Narrow product: sources are extended to the product width, then
  // multiplied. The truncated product is correct for both signednesses.
  function automatic logic [PROD_N_W-1:0] mul_narrow_fn(input logic [WORD_W-1:0] a,
                                                        input logic [WORD_W-1:0] b,
                                                        input logic sgn);
    logic [PROD_N_W-1:0] xa;
    logic [PROD_N_W-1:0] xb;
    xa = {{(PROD_N_W-NARROW_W){sgn & a[NARROW_W-1]}}, a[NARROW_W-1:0]};
    xb = {{(PROD_N_W-NARROW_W){sgn & b[NARROW_W-1]}}, b[NARROW_W-1:0]};
    return xa * xb;
  endfunction

  function automatic logic [PROD_W_W-1:0] extend_wide_fn(input logic [WORD_W-1:0] a,
                                                         input logic sgn);
    return {{(PROD_W_W-WORD_W){sgn & a[WORD_W-1]}}, a};
  endfunction
endpackage

// File: rtl/ialu_fast_path.sv
module ialu_fast_path
  import ialu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] c,
  input  logic              cin,
  output logic [WORD_W-1:0] result,
  output logic              carry
);
  logic [WORD_W:0]   sum_w;
  logic [PROD_N_W-1:0] prod_n;
  logic [HIGH_N_W-1:0] prod_hi;

  assign sum_w   = addsub_fn(op, a, b, cin);
  assign prod_n  = mul_narrow_fn(a, b, op[0]);
  assign prod_hi = prod_n[PROD_N_W-1 -: HIGH_N_W];

  always_comb begin
    result = '0;
    carry  = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBB: begin
        result = sum_w[WORD_W-1:0];
        carry  = sum_w[WORD_W];
      end
      OP_MUL24_U, OP_MUL24_S: result = prod_n[WORD_W-1:0];
      OP_MAD24_U, OP_MAD24_S: result = prod_n[WORD_W-1:0] + c;
      OP_MULHI24_U: result = {{(WORD_W-HIGH_N_W){1'b0}}, prod_hi};
      OP_MULHI24_S: result = {{(WORD_W-HIGH_N_W){prod_hi[HIGH_N_W-1]}}, prod_hi};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/ialu_slow_mul.sv
module ialu_slow_mul
  import ialu_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  logic [CNT_W-1:0]    cnt;
  logic [PROD_W_W-1:0] opa_x;
  logic [PROD_W_W-1:0] opb_x;
  logic                take_hi;
  logic [PROD_W_W-1:0] prod_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      opa_x   <= '0;
      opb_x   <= '0;
      take_hi <= 1'b0;
    end else if (start) begin
      cnt     <= CNT_LOAD;
      opa_x   <= extend_wide_fn(a, op[0]);
      opb_x   <= extend_wide_fn(b, op[0]);
      take_hi <= (op == OP_MULHI_U) || (op == OP_MULHI_S);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // The operands stay in their registers for LAT-1 cycles, so the
  // product logic has that many cycles to settle.
  assign prod_w = opa_x * opb_x;
  assign busy   = (cnt != '0);
  assign done   = (cnt == CNT_W'(1));
  assign result = take_hi ? prod_w[PROD_W_W-1:WORD_W] : prod_w[WORD_W-1:0];
endmodule

// File: rtl/int_alu_lane.sv
module int_alu_lane
  import ialu_pkg::*;
#(
  parameter int SLOW_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [WORD_W-1:0] in_c,
  input  logic              in_cin,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_carry
);
  logic              issue;
  logic              fast_issue;
  logic              slow_issue;
  logic              slow_busy;
  logic              slow_done;
  logic [WORD_W-1:0] fast_result;
  logic              fast_carry;
  logic [WORD_W-1:0] slow_result;

  assign in_ready   = ~slow_busy;
  assign issue      = in_valid & in_ready;
  assign slow_issue = issue & op_is_slow(in_op);
  assign fast_issue = issue & ~op_is_slow(in_op);

  ialu_fast_path u_fast (
    .op     (in_op),
    .a      (in_a),
    .b      (in_b),
    .c      (in_c),
    .cin    (in_cin),
    .result (fast_result),
    .carry  (fast_carry)
  );

  ialu_slow_mul #(.LAT(SLOW_LAT)) u_slow (
    .clk    (clk),
    .rst    (rst),
    .start  (slow_issue),
    .op     (in_op),
    .a      (in_a),
    .b      (in_b),
    .busy   (slow_busy),
    .done   (slow_done),
    .result (slow_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
    end else if (fast_issue) begin
      out_valid  <= 1'b1;
      out_result <= fast_result;
      out_carry  <= fast_carry;
    end else if (slow_done) begin
      out_valid  <= 1'b1;
      out_result <= slow_result;
      out_carry  <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ialu_lane_chk.sv
module ialu_lane_chk #(
  parameter int SLOW_LAT = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic [3:0] in_op,
  input logic       out_valid,
  input logic       out_carry,
  input logic       fast_issue,
  input logic       slow_issue
);
  logic       rst_q;
  logic [7:0] wait_cnt;
  logic [1:0] pending;
  logic       last_nocarry;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      wait_cnt     <= '0;
      pending      <= '0;
      last_nocarry <= 1'b0;
    end else begin
      if (slow_issue) wait_cnt <= 8'(SLOW_LAT - 1);
      else if (wait_cnt != 0) wait_cnt <= wait_cnt - 8'd1;
      pending <= pending + {1'b0, fast_issue | slow_issue} - {1'b0, out_valid};
      if (fast_issue | slow_issue) last_nocarry <= (in_op >= 4'd4);
    end
  end

  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!out_valid && in_ready));
  // R7
  fast_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fast_issue |=> (out_valid && in_ready));
  // R8
  slow_stall_chk: assert property (@(posedge clk) disable iff (rst)
    slow_issue |=> (!in_ready && !out_valid));
  // R8
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_cnt > 8'd1) |=> !in_ready);
  // R8
  slow_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_cnt == 8'd1) |=> (out_valid && in_ready));
  // R9
  mul_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && last_nocarry) |-> !out_carry);
  // R12
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pending != 2'd0));
endmodule

bind int_alu_lane ialu_lane_chk #(.SLOW_LAT(SLOW_LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_carry  (out_carry),
  .fast_issue (fast_issue),
  .slow_issue (slow_issue)
);

// File: tb/int_alu_lane_test.sv
`timescale 1ns/100ps
module int_alu_lane_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_c = '0;
  logic        in_cin = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  int_alu_lane uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_cin(in_cin),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [63:0] m24(input logic [31:0] a, input logic [31:0] b,
                                      input bit s);
    longint x, y;
    if (s) begin
      x = longint'($signed(a[23:0]));
      y = longint'($signed(b[23:0]));
    end else begin
      x = longint'(a[23:0]);
      y = longint'(b[23:0]);
    end
    return 64'(x * y);
  endfunction

  function automatic logic [63:0] m32(input logic [31:0] a, input logic [31:0] b,
                                      input bit s);
    logic [63:0] ua, ub;
    if (s) return 64'(longint'($signed(a)) * longint'($signed(b)));
    ua = {32'b0, a};
    ub = {32'b0, b};
    return ua * ub;
  endfunction

  // {carry, result}
  function automatic logic [32:0] expect_of(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] c,
                                            input logic cin);
    logic [63:0] p;
    case (op)
      4'd0: return {1'b0, a} + {1'b0, b};
      4'd1: return {1'b0, a} - {1'b0, b};
      4'd2: return {1'b0, a} + {1'b0, b} + 33'(cin);
      4'd3: return {1'b0, a} - {1'b0, b} - 33'(cin);
      4'd4, 4'd5: begin p = m24(a, b, op[0]); return {1'b0, p[31:0]}; end
      4'd6, 4'd7: begin p = m24(a, b, op[0]); return {1'b0, p[31:0] + c}; end
      4'd8: begin p = m24(a, b, 1'b0); return {17'b0, p[47:32]}; end
      4'd9: begin p = m24(a, b, 1'b1); return {1'b0, {16{p[47]}}, p[47:32]}; end
      4'd10, 4'd11: begin p = m32(a, b, op[0]); return {1'b0, p[31:0]}; end
      4'd12, 4'd13: begin p = m32(a, b, op[0]); return {1'b0, p[63:32]}; end
      default: return 33'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6, 4'd7: return "R4";
      4'd8, 4'd9: return "R5";
      4'd10, 4'd11, 4'd12, 4'd13: return "R6";
      default: return "R10";
    endcase
  endfunction

  // One isolated issue, with full timing checks. Called at a negedge.
  task automatic run_one(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic cin);
    logic [32:0] e;
    e = expect_of(op, a, b, c, cin);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c; in_cin = cin;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (op >= 4'd10 && op <= 4'd13) begin
      for (int k = 0; k < 3; k++) begin
        chk(!in_ready && !out_valid, "R8 stall", {62'b0, in_ready, out_valid}, 64'd0);
        // junk issue attempts during the stall must be ignored (R8)
        in_valid = (k < 2);
        in_op = 4'd0; in_a = $urandom; in_b = $urandom;
        if (k < 2) begin @(posedge clk); @(negedge clk); end
      end
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    chk(out_valid && in_ready, {tag_of(op), " R7/R8 valid"}, {62'b0, out_valid, in_ready}, 64'd3);
    chk(out_result == e[31:0], tag_of(op), {32'b0, out_result}, {32'b0, e[31:0]});
    chk(out_carry == e[32], (op >= 4'd4) ? "R9 carry" : tag_of(op), 64'(out_carry), 64'(e[32]));
    @(posedge clk); @(negedge clk);
    chk(!out_valid, "R12 single pulse", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [32:0] prev_e;
    logic [3:0]  prev_op;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!out_valid && in_ready, "R11 reset", {62'b0, out_valid, in_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);

    // directed corner cases
    run_one(4'd0, 32'hFFFF_FFFF, 32'd1, 0, 1'b0);          // R1 carry
    run_one(4'd1, 32'd0, 32'd1, 0, 1'b0);                  // R1 borrow
    run_one(4'd1, 32'd7, 32'd7, 0, 1'b0);                  // R1 no borrow
    run_one(4'd2, 32'hFFFF_FFFF, 32'd0, 0, 1'b1);          // R2 carry in
    run_one(4'd3, 32'd0, 32'hFFFF_FFFF, 0, 1'b1);          // R2 borrow chain
    run_one(4'd3, 32'd5, 32'd4, 0, 1'b1);                  // R2 exact zero
    run_one(4'd4, 32'hFF00_0003, 32'hAB00_0002, 0, 1'b1);  // R3 upper bits ignored
    run_one(4'd5, 32'h0080_0000, 32'h0080_0000, 0, 1'b0);  // R3 most negative
    run_one(4'd7, 32'h00FF_FFFF, 32'd3, 32'h0000_0010, 0); // R4 signed mad
    run_one(4'd6, 32'h00FF_FFFF, 32'h00FF_FFFF, 32'hFFFF_FFFF, 0); // R4 wrap
    run_one(4'd9, 32'h00FF_FFFF, 32'd1, 0, 1'b0);          // R5 sign extension
    run_one(4'd8, 32'h00FF_FFFF, 32'h00FF_FFFF, 0, 1'b0);  // R5 zero extension
    run_one(4'd11, 32'h8000_0000, 32'h8000_0000, 0, 1'b0); // R6
    run_one(4'd13, 32'h8000_0000, 32'h8000_0000, 0, 1'b0); // R6
    run_one(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0); // R6
    run_one(4'd13, 32'hFFFF_FFFF, 32'd2, 0, 1'b0);         // R6
    run_one(4'd14, 32'h1234_5678, 32'h9, 32'h5, 1'b1);     // R10
    run_one(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b1); // R10

    // R7: back-to-back random fast ops, one per cycle
    prev_op = '0; prev_e = '0;
    for (int i = 0; i <= 200; i++) begin
      if (i > 0) begin
        chk(out_valid && in_ready, "R7 back-to-back", {62'b0, out_valid, in_ready}, 64'd3);
        chk(out_result == prev_e[31:0], tag_of(prev_op), {32'b0, out_result}, {32'b0, prev_e[31:0]});
        chk(out_carry == prev_e[32], "R9/R1 carry", 64'(out_carry), 64'(prev_e[32]));
      end
      if (i < 200) begin
        int r;
        r = int'($urandom % 12);
        in_valid = 1'b1;
        in_op = (r < 10) ? 4'(r) : 4'(r + 4);
        in_a = $urandom; in_b = $urandom; in_c = $urandom; in_cin = 1'($urandom);
        prev_op = in_op;
        prev_e = expect_of(in_op, in_a, in_b, in_c, in_cin);
        @(posedge clk); @(negedge clk);
      end
    end
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);

    // random wide multiplies with stall checks (R6, R8)
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 5 == 0) ra[31] = 1'b1;
      run_one(4'(10 + ($urandom % 4)), ra, rb, $urandom, 1'($urandom));
    end

    // R11: reset while a wide multiply is in flight
    in_valid = 1'b1; in_op = 4'd12; in_a = 32'hDEAD_BEEF; in_b = 32'h1234_5678;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!out_valid && in_ready, "R11 mid-flight reset", {62'b0, out_valid, in_ready}, 64'd1);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk(!out_valid && in_ready, "R11 no stale result", {62'b0, out_valid, in_ready}, 64'd1);
    end
    run_one(4'd0, 32'd40, 32'd2, 0, 1'b0);  // R1 after reset

    summary();
  end
endmodule